// File: doc/BRIEF.md
# Serviced Watchdog Timer on a Shared Prescaler

The block is a watchdog timer. A free-running prescaler counter is shared with the rest of the system. Each time that prescaler wraps, a narrow watchdog counter advances by one. If the watchdog counter wraps from all ones to zero, the block issues a one-cycle reset request and sets a sticky watchdog status flag.

Software keeps the system alive by writing to one fixed service address. The data value of the write does not matter. A service write clears the watchdog counter. It also clears only the upper band of the prescaler. The low prescaler bits keep counting through the write.

For test and debug, the watchdog is held off by a purely combinational gate. The gate opens when a high-voltage test indication is present on the reset pin or on the interrupt pin while the part is in monitor mode. It also opens when the high voltage is on the reset pin during a break state. Nothing stores the disable condition, so a brief glitch cannot latch the watchdog off.

All controls are plain level or strobe signals. The block has no streaming data path, so there is no valid/ready handshake.

Top module: `svc_watchdog`

## Requirements
- R1: While the system reset `rst_n` is low, `rst_req` is 0. While `por_n` is low, `wdog_flag` is 0.
- R2: The prescaler (PRE_W bits) and the watchdog counter (WDT_W bits) restart from zero when reset is released. Counting is never disabled. The first `rst_req` is seen after clock edge number 2^(PRE_W+WDT_W), counting edge 1 as the first edge after release.
- R3: `rst_req` is high for exactly one cycle per overflow. Without service, overflows repeat every 2^(PRE_W+WDT_W) edges.
- R4: A service write is `bus_wr`=1 with `bus_addr` equal to SVC_ADDR (default all ones). It clears the watchdog counter and prescaler bits PRE_W-1 down to SVC_LO. Prescaler bits below SVC_LO still count. Take a service write at edge s, where s is not an edge at which the prescaler wraps. The next request then follows edge s + 2^(PRE_W+WDT_W) − (s mod 2^SVC_LO).
- R5: A write to any other address, or any address value with `bus_wr`=0, leaves the timing of R2 unchanged.
- R6: The watchdog is disabled while `mon_mode`=1 and either `hv_on_rst` or `hv_on_irq` is 1. While disabled, no request is issued.
- R7: The watchdog is disabled while `brk_state`=1 and `hv_on_rst`=1. The following leave it running: `brk_state` with only `hv_on_irq`, `hv_on_rst` alone, and `mon_mode` alone.
- R8: The disable is not stored. While disabled, the watchdog counter holds its value, and it resumes from that value when the condition drops. A one-cycle disable that misses a prescaler wrap has no effect on timing.
- R9: `wdog_flag` is set in the same cycle as `rst_req`. It stays set through a system reset on `rst_n`.
- R10: `wdog_flag` is cleared by a one-cycle `stat_clr` pulse, or by `por_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset for the prescaler, the counter and the request |
| por_n | input | 1 | Active-low power-on reset for the status flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| mon_mode | input | 1 | Monitor (test) mode qualifier |
| hv_on_rst | input | 1 | High-voltage test level detected on the reset pin |
| hv_on_irq | input | 1 | High-voltage test level detected on the interrupt pin |
| brk_state | input | 1 | Debug break state |
| stat_clr | input | 1 | Software clear of the status flag |
| rst_req | output | 1 | One-cycle internal reset request on overflow |
| wdog_flag | output | 1 | Sticky watchdog-caused-reset flag |

## Verification
The bench uses a small configuration: a 6-bit prescaler, a 2-bit kept low field and a 3-bit watchdog counter, which gives a 512-cycle timeout. The bench sweeps the service write across every edge of one prescaler period. The expected request edge depends on the low bits of the service edge. This separates three cases: clearing only the upper band, clearing the whole prescaler, and clearing nothing.

Wrong addresses and writes with the strobe low must leave the unserviced timing intact. Every combination of mode, break and high-voltage inputs is applied for a long run to split the disabling pairs from the harmless ones.

A disable window that covers three prescaler wraps must delay the request by exactly three wrap periods. A one-cycle glitch must delay it by nothing. These two cases show that the counter holds its value while disabled and that the disable is never latched.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DEF_PRE_W  = 13;
  localparam int DEF_SVC_LO = 5;
  localparam int DEF_WDT_W  = 6;
  localparam int DEF_ADDR_W = 16;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int PRE_W  = 13,
  parameter int SVC_LO = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc,
  output logic wrap
);
  localparam logic [PRE_W-1:0] KEEP = PRE_W'((1 << SVC_LO) - 1);
  localparam logic [PRE_W-1:0] ONE  = PRE_W'(1);

  logic [PRE_W-1:0] pre;

  // service zeroes the upper band; low field keeps counting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (svc) pre <= (pre + ONE) & KEEP;
    else          pre <= pre + ONE;
  end

  assign wrap = &pre;

  a_r4_band_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !wrap);
endmodule

// File: rtl/wdg_gate.sv
module wdg_gate (
  input  logic mon_mode,
  input  logic hv_on_rst,
  input  logic hv_on_irq,
  input  logic brk_state,
  output logic off
);
  // purely combinational: no state can hold the watchdog off
  always_comb begin
    off = 1'b0;
    if (mon_mode && (hv_on_rst || hv_on_irq)) off = 1'b1;
    if (brk_state && hv_on_rst)               off = 1'b1;
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int WDT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc,
  input  logic             adv,
  output logic             ovf,
  output logic [WDT_W-1:0] cnt
);
  localparam logic [WDT_W-1:0] ONE = WDT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (svc) cnt <= '0;
    else if (adv) cnt <= cnt + ONE;
  end

  assign ovf = adv && !svc && (&cnt);

  a_r4_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (cnt == '0));
  a_r8_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !svc) |=> $stable(cnt));
endmodule

// File: rtl/wdg_flag.sv
module wdg_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  a_r10_clear_source: assert property (@(posedge clk) disable iff (!por_n)
    $fell(flag) |-> $past(clr));
  a_r9_set_sticks: assert property (@(posedge clk) disable iff (!por_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdg_pkg::*;
#(
  parameter int                PRE_W    = DEF_PRE_W,
  parameter int                SVC_LO   = DEF_SVC_LO,
  parameter int                WDT_W    = DEF_WDT_W,
  parameter int                ADDR_W   = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              mon_mode,
  input  logic              hv_on_rst,
  input  logic              hv_on_irq,
  input  logic              brk_state,
  input  logic              stat_clr,
  output logic              rst_req,
  output logic              wdog_flag
);
  logic             svc, tick, off, adv, ovf;
  logic [WDT_W-1:0] cnt;

  assign svc = bus_wr && (bus_addr == SVC_ADDR);
  assign adv = tick && !off;

  wdg_prescale #(.PRE_W(PRE_W), .SVC_LO(SVC_LO)) u_pre (
    .clk(clk), .rst_n(rst_n), .svc(svc), .wrap(tick));

  wdg_gate u_gate (
    .mon_mode(mon_mode), .hv_on_rst(hv_on_rst), .hv_on_irq(hv_on_irq),
    .brk_state(brk_state), .off(off));

  wdg_count #(.WDT_W(WDT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .svc(svc), .adv(adv), .ovf(ovf), .cnt(cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= ovf;
  end

  wdg_flag u_flag (
    .clk(clk), .por_n(por_n), .set(ovf), .clr(stat_clr), .flag(wdog_flag));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r2_req_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(tick));
  a_r6_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(off));
  a_r9_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |-> wdog_flag);
endmodule

// File: tb/svc_watchdog_test.sv
module svc_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W  = 6;
  localparam int SVC_LO = 2;
  localparam int WDT_W  = 3;
  localparam int TOUT   = 1 << (PRE_W + WDT_W);

  logic clk = 0, rst_n = 0, por_n = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic mon_mode = 0, hv_on_rst = 0, hv_on_irq = 0, brk_state = 0, stat_clr = 0;
  logic rst_req, wdog_flag;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svc_watchdog #(.PRE_W(PRE_W), .SVC_LO(SVC_LO), .WDT_W(WDT_W), .ADDR_W(16),
                 .SVC_ADDR(16'hFFFF)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .mon_mode(mon_mode), .hv_on_rst(hv_on_rst), .hv_on_irq(hv_on_irq),
    .brk_state(brk_state), .stat_clr(stat_clr), .rst_req(rst_req), .wdog_flag(wdog_flag));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); chk("R1 req in reset", rst_req, 0);
    rst_n = 1;
  endtask

  // edge k = k-th rising edge after release; inputs set at the negedge before it
  task automatic run(int n, int svc_k, logic wr, logic [15:0] a, int d_lo, int d_hi,
                     output int first, output int cnt);
    first = 0; cnt = 0;
    for (int k = 1; k <= n; k++) begin
      bus_wr   = wr && (k == svc_k);
      bus_addr = (k == svc_k) ? a : 16'h0000;
      if (d_hi >= d_lo) begin
        mon_mode  = (k >= d_lo && k <= d_hi);
        hv_on_rst = (k >= d_lo && k <= d_hi);
      end
      @(posedge clk); @(negedge clk);
      if (rst_req) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
    bus_wr = 0; mon_mode = 0; hv_on_rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f, c;
    repeat (2) @(negedge clk);
    chk("R1 req", rst_req, 0);
    chk("R1 flag", wdog_flag, 0);
    por_n = 1;
    sys_reset();
    run(TOUT + 80, 0, 0, 0, 0, -1, f, c);
    chk("R2 first request edge", f, TOUT);
    chk("R3 single pulse", c, 1);
    chk("R9 flag set", wdog_flag, 1);
    sys_reset();
    chk("R9 flag survives reset", wdog_flag, 1);
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
    chk("R10 flag cleared by stat_clr", wdog_flag, 0);
    sys_reset();
    run(2 * TOUT + 20, 0, 0, 0, 0, -1, f, c);
    chk("R3 periodic count", c, 2);
    @(negedge clk); por_n = 0; @(negedge clk);
    chk("R10 flag cleared by por", wdog_flag, 0);
    por_n = 1;

    // R4 sweep across one prescaler period
    for (int s = 65; s <= 127; s++) begin
      sys_reset();
      run(TOUT + 140, s, 1, 16'hFFFF, 0, -1, f, c);
      chk($sformatf("R4 service at %0d", s), f, s + TOUT - (s % (1 << SVC_LO)));
      chk("R4 one pulse", c, 1);
    end

    // R5 non-service writes
    sys_reset(); run(TOUT + 10, 101, 1, 16'hFFFE, 0, -1, f, c);
    chk("R5 addr FFFE", f, TOUT);
    sys_reset(); run(TOUT + 10, 101, 1, 16'h7FFF, 0, -1, f, c);
    chk("R5 addr 7FFF", f, TOUT);
    sys_reset(); run(TOUT + 10, 101, 1, 16'h0000, 0, -1, f, c);
    chk("R5 addr 0000", f, TOUT);
    sys_reset(); run(TOUT + 10, 101, 0, 16'hFFFF, 0, -1, f, c);
    chk("R5 strobe low", f, TOUT);

    // R6 / R7 sweep all 16 input combinations
    for (int m = 0; m < 16; m++) begin
      int exp_first;
      logic dis;
      dis = (m[0] && (m[1] || m[2])) || (m[3] && m[1]);
      sys_reset();
      mon_mode = m[0]; hv_on_rst = m[1]; hv_on_irq = m[2]; brk_state = m[3];
      for (int k = 1; k <= 2 * TOUT + 10; k++) begin
        @(posedge clk); @(negedge clk);
        if (rst_req && f == 0) f = k;
        if (k == 1) f = 0;
      end
      exp_first = dis ? 0 : TOUT;
      chk($sformatf("R6 R7 combo mon=%0d hvr=%0d hvi=%0d brk=%0d", m[0], m[1], m[2], m[3]),
          f, exp_first);
      mon_mode = 0; hv_on_rst = 0; hv_on_irq = 0; brk_state = 0;
    end

    // R8 hold and resume, glitch
    sys_reset(); run(TOUT + 300, 0, 0, 0, 1, 200, f, c);
    chk("R8 held through 3 wraps", f, TOUT + 3 * (1 << PRE_W));
    sys_reset(); run(TOUT + 10, 0, 0, 0, 10, 10, f, c);
    chk("R8 glitch no effect", f, TOUT);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule